// File: doc/BRIEF.md
# Pair Cutoff Distance Filter

This block is the pair-screening stage in front of a short-range force pipeline. On each cycle it can take in one candidate atom pair: two atom identifiers and two fixed-point position triples. It forms the three displacement components, sums their squares, and compares that squared distance with a programmable squared cutoff. Because the test uses squared values, no square root is needed. Only pairs that fall strictly inside the cutoff sphere, and that are made of two distinct atoms, leave the block. Every other pair is discarded without any trace.

The output is a valid/ready stream that fills a FIFO in front of the force stage. The number of outputs depends on the data: a full input stream can produce anything from zero records to one record per cycle. The block sequences itself and does not coordinate with the consumer. The only interaction is back-pressure. When the emitted record is refused, the whole pipeline freezes in place. A discarded pair never causes a freeze.

Top module: `pair_cutoff_filter`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and the squared-cutoff register holds the parameter RC2_INIT (default 1024).
- R2: While the output is not stalled, in_ready stays 1, so a new pair is accepted on every clock edge at which in_valid is 1.
- R3: An emitted record carries in_id_a and in_id_b unchanged. Each displacement is the B coordinate minus the A coordinate, as a COORD_W+1 bit two's-complement value. out_dist2 is dx*dx + dy*dy + dz*dz.
- R4: A pair is emitted only when its squared distance is strictly less than the squared cutoff. A pair exactly on the cutoff, or beyond it, produces no output. With a cutoff of 0, nothing is emitted.
- R5: A pair whose two identifiers are equal is never emitted, even when its distance is zero.
- R6: The latency is fixed. A pair accepted at clock edge E appears on out_valid right after edge E+2, as long as no stall intervenes.
- R7: While out_valid is 1 and out_ready is 0, the record is held stable and the pipeline does not advance. Every accepted pair that passes the filter is emitted exactly once, in acceptance order.
- R8: A write with cfg_we at a clock edge loads cfg_rc2 into the squared-cutoff register. Pairs compared after that edge use the new value.
- R9: in_ready is 0 only when a valid output is being refused. Discarded pairs never stall the input, even while out_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the squared-cutoff register |
| cfg_rc2 | input | 2*COORD_W+2 | New squared cutoff |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_id_a | input | ID_W | Identifier of atom A |
| in_id_b | input | ID_W | Identifier of atom B |
| in_ax | input | COORD_W | Atom A x position, unsigned |
| in_ay | input | COORD_W | Atom A y position, unsigned |
| in_az | input | COORD_W | Atom A z position, unsigned |
| in_bx | input | COORD_W | Atom B x position, unsigned |
| in_by | input | COORD_W | Atom B y position, unsigned |
| in_bz | input | COORD_W | Atom B z position, unsigned |
| out_valid | output | 1 | Record present |
| out_ready | input | 1 | Downstream FIFO can accept |
| out_id_a | output | ID_W | Identifier of atom A |
| out_id_b | output | ID_W | Identifier of atom B |
| out_dx | output | COORD_W+1 | Signed x displacement B-A |
| out_dy | output | COORD_W+1 | Signed y displacement B-A |
| out_dz | output | COORD_W+1 | Signed z displacement B-A |
| out_dist2 | output | 2*COORD_W+2 | Squared distance |

## Verification
Two things can happen in the same cycle: the output is refused, and a new pair is offered or an in-flight pair is being discarded. The bench provokes this by driving out_ready from a pseudo-random sequence while pairs stream in back to back. It checks that the refused record stays frozen, that in_ready drops, and that no pair is lost or repeated. A second case holds out_ready low while only pairs that will be discarded are sent. It checks that the input keeps flowing at one pair per cycle and that out_valid never rises.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  localparam int PCF_AXES    = 3;
  localparam int PCF_LATENCY = 3;

  typedef enum logic [1:0] {
    PCF_EV_IDLE = 2'd0,
    PCF_EV_KEEP = 2'd1,
    PCF_EV_FAR  = 2'd2,
    PCF_EV_SELF = 2'd3
  } pcf_event_e;
endpackage

// File: rtl/pcf_delta_stage.sv
module pcf_delta_stage
  import pcf_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int ID_W    = 12
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 en,
  input  logic                                 in_vld,
  input  logic [ID_W-1:0]                      in_ia,
  input  logic [ID_W-1:0]                      in_ib,
  input  logic [PCF_AXES-1:0][COORD_W-1:0]     pos_a,
  input  logic [PCF_AXES-1:0][COORD_W-1:0]     pos_b,
  output logic                                 vld,
  output logic [ID_W-1:0]                      ia,
  output logic [ID_W-1:0]                      ib,
  output logic                                 self_pair,
  output logic [PCF_AXES-1:0][COORD_W:0]       delta
);
  // B minus A, widened by one bit so that the two's-complement result never wraps
  function automatic logic [COORD_W:0] axis_delta(input logic [COORD_W-1:0] a,
                                                  input logic [COORD_W-1:0] b);
    return {1'b0, b} - {1'b0, a};
  endfunction

  logic [PCF_AXES-1:0][COORD_W:0] delta_nxt;

  for (genvar g = 0; g < PCF_AXES; g++) begin : g_axis
    assign delta_nxt[g] = axis_delta(pos_a[g], pos_b[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld       <= 1'b0;
      ia        <= '0;
      ib        <= '0;
      self_pair <= 1'b0;
      delta     <= '0;
    end else if (en) begin
      vld       <= in_vld;
      ia        <= in_ia;
      ib        <= in_ib;
      self_pair <= (in_ia == in_ib);
      delta     <= delta_nxt;
    end
  end
endmodule

// File: rtl/pcf_square_stage.sv
module pcf_square_stage
  import pcf_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int ID_W    = 12,
  parameter int D2_W    = 2*COORD_W+2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en,
  input  logic                             in_vld,
  input  logic [ID_W-1:0]                  in_ia,
  input  logic [ID_W-1:0]                  in_ib,
  input  logic                             in_self,
  input  logic [PCF_AXES-1:0][COORD_W:0]   in_delta,
  output logic                             vld,
  output logic [ID_W-1:0]                  ia,
  output logic [ID_W-1:0]                  ib,
  output logic                             self_pair,
  output logic [PCF_AXES-1:0][COORD_W:0]   delta,
  output logic [D2_W-1:0]                  dist2
);
  localparam int SQ_W = 2*COORD_W;

  // The magnitude of a signed displacement always fits in COORD_W bits
  function automatic logic [COORD_W-1:0] magnitude(input logic [COORD_W:0] d);
    logic [COORD_W:0] n;
    n = d[COORD_W] ? (~d + 1'b1) : d;
    return n[COORD_W-1:0];
  endfunction

  function automatic logic [SQ_W-1:0] square(input logic [COORD_W-1:0] m);
    logic [SQ_W-1:0] w;
    w = {{COORD_W{1'b0}}, m};
    return w * w;
  endfunction

  logic [PCF_AXES-1:0][SQ_W-1:0] sq_term;
  logic [D2_W-1:0]               sum_nxt;

  for (genvar g = 0; g < PCF_AXES; g++) begin : g_sq
    assign sq_term[g] = square(magnitude(in_delta[g]));
  end

  always_comb begin
    sum_nxt = '0;
    for (int i = 0; i < PCF_AXES; i++) begin
      sum_nxt = sum_nxt + D2_W'(sq_term[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld       <= 1'b0;
      ia        <= '0;
      ib        <= '0;
      self_pair <= 1'b0;
      delta     <= '0;
      dist2     <= '0;
    end else if (en) begin
      vld       <= in_vld;
      ia        <= in_ia;
      ib        <= in_ib;
      self_pair <= in_self;
      delta     <= in_delta;
      dist2     <= sum_nxt;
    end
  end
endmodule

// File: rtl/pcf_cutoff_reg.sv
module pcf_cutoff_reg #(
  parameter int              D2_W     = 34,
  parameter logic [D2_W-1:0] RC2_INIT = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [D2_W-1:0] wdata,
  output logic [D2_W-1:0] rc2
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rc2 <= RC2_INIT;
    else if (we) rc2 <= wdata;
  end
endmodule

// File: rtl/pcf_select_stage.sv
module pcf_select_stage
  import pcf_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int ID_W    = 12,
  parameter int D2_W    = 2*COORD_W+2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             en,
  input  logic                             in_vld,
  input  logic [ID_W-1:0]                  in_ia,
  input  logic [ID_W-1:0]                  in_ib,
  input  logic                             in_self,
  input  logic [PCF_AXES-1:0][COORD_W:0]   in_delta,
  input  logic [D2_W-1:0]                  in_dist2,
  input  logic [D2_W-1:0]                  rc2,
  output pcf_event_e                       evt,
  output logic                             vld,
  output logic [ID_W-1:0]                  ia,
  output logic [ID_W-1:0]                  ib,
  output logic [PCF_AXES-1:0][COORD_W:0]   delta,
  output logic [D2_W-1:0]                  dist2
);
  // The self test comes first, so a zero-distance pair of one atom is never kept
  function automatic pcf_event_e classify(input logic v, input logic s,
                                          input logic [D2_W-1:0] d2,
                                          input logic [D2_W-1:0] lim);
    if (!v)       return PCF_EV_IDLE;
    if (s)        return PCF_EV_SELF;
    if (d2 < lim) return PCF_EV_KEEP;
    return PCF_EV_FAR;
  endfunction

  assign evt = classify(in_vld, in_self, in_dist2, rc2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld   <= 1'b0;
      ia    <= '0;
      ib    <= '0;
      delta <= '0;
      dist2 <= '0;
    end else if (en) begin
      vld   <= (evt == PCF_EV_KEEP);
      ia    <= in_ia;
      ib    <= in_ib;
      delta <= in_delta;
      dist2 <= in_dist2;
    end
  end
endmodule

// File: rtl/pair_cutoff_filter.sv
module pair_cutoff_filter
  import pcf_pkg::*;
#(
  parameter int                   COORD_W  = 16,
  parameter int                   ID_W     = 12,
  parameter logic [2*COORD_W+1:0] RC2_INIT = 1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [2*COORD_W+1:0]   cfg_rc2,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [ID_W-1:0]        in_id_a,
  input  logic [ID_W-1:0]        in_id_b,
  input  logic [COORD_W-1:0]     in_ax,
  input  logic [COORD_W-1:0]     in_ay,
  input  logic [COORD_W-1:0]     in_az,
  input  logic [COORD_W-1:0]     in_bx,
  input  logic [COORD_W-1:0]     in_by,
  input  logic [COORD_W-1:0]     in_bz,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [ID_W-1:0]        out_id_a,
  output logic [ID_W-1:0]        out_id_b,
  output logic [COORD_W:0]       out_dx,
  output logic [COORD_W:0]       out_dy,
  output logic [COORD_W:0]       out_dz,
  output logic [2*COORD_W+1:0]   out_dist2
);
  localparam int D2_W = 2*COORD_W+2;

  // Named internal events, brought out for the checker
  logic       adv;
  logic       keep_evt;
  logic       drop_evt;
  pcf_event_e s2_evt;

  logic [PCF_AXES-1:0][COORD_W-1:0] pos_a, pos_b;
  assign pos_a = {in_az, in_ay, in_ax};
  assign pos_b = {in_bz, in_by, in_bx};

  logic                           s1_vld, s1_self;
  logic [ID_W-1:0]                s1_ia, s1_ib;
  logic [PCF_AXES-1:0][COORD_W:0] s1_delta;

  logic                           s2_vld, s2_self;
  logic [ID_W-1:0]                s2_ia, s2_ib;
  logic [PCF_AXES-1:0][COORD_W:0] s2_delta;
  logic [D2_W-1:0]                s2_dist2;

  logic [D2_W-1:0]                rc2_q;
  logic [PCF_AXES-1:0][COORD_W:0] o_delta;

  // A single enable for every stage: only a refused valid record freezes the pipe
  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv;
  assign keep_evt = adv && (s2_evt == PCF_EV_KEEP);
  assign drop_evt = adv && ((s2_evt == PCF_EV_FAR) || (s2_evt == PCF_EV_SELF));

  pcf_cutoff_reg #(.D2_W(D2_W), .RC2_INIT(RC2_INIT)) u_cutoff (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_rc2), .rc2(rc2_q)
  );

  pcf_delta_stage #(.COORD_W(COORD_W), .ID_W(ID_W)) u_delta (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .in_vld(in_valid), .in_ia(in_id_a), .in_ib(in_id_b),
    .pos_a(pos_a), .pos_b(pos_b),
    .vld(s1_vld), .ia(s1_ia), .ib(s1_ib), .self_pair(s1_self), .delta(s1_delta)
  );

  pcf_square_stage #(.COORD_W(COORD_W), .ID_W(ID_W), .D2_W(D2_W)) u_square (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .in_vld(s1_vld), .in_ia(s1_ia), .in_ib(s1_ib), .in_self(s1_self),
    .in_delta(s1_delta),
    .vld(s2_vld), .ia(s2_ia), .ib(s2_ib), .self_pair(s2_self),
    .delta(s2_delta), .dist2(s2_dist2)
  );

  pcf_select_stage #(.COORD_W(COORD_W), .ID_W(ID_W), .D2_W(D2_W)) u_select (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .in_vld(s2_vld), .in_ia(s2_ia), .in_ib(s2_ib), .in_self(s2_self),
    .in_delta(s2_delta), .in_dist2(s2_dist2), .rc2(rc2_q),
    .evt(s2_evt),
    .vld(out_valid), .ia(out_id_a), .ib(out_id_b),
    .delta(o_delta), .dist2(out_dist2)
  );

  assign out_dx = o_delta[0];
  assign out_dy = o_delta[1];
  assign out_dz = o_delta[2];
endmodule

// File: rtl/pcf_checker.sv
module pcf_checker #(
  parameter int COORD_W = 16,
  parameter int ID_W    = 12,
  parameter int D2_W    = 34
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ID_W-1:0]  out_id_a,
  input logic [ID_W-1:0]  out_id_b,
  input logic [COORD_W:0] out_dx,
  input logic [D2_W-1:0]  out_dist2,
  input logic             s1_vld,
  input logic             keep_evt,
  input logic             drop_evt,
  input logic [D2_W-1:0]  s2_dist2
);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> s1_vld);

  assert_keep_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    keep_evt |=> (out_valid && out_dist2 == $past(s2_dist2)));

  assert_drop_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !out_valid);

  assert_no_self_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_id_a != out_id_b));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_dist2) && $stable(out_id_a) &&
       $stable(out_id_b) && $stable(out_dx)));
endmodule

bind pair_cutoff_filter pcf_checker #(
  .COORD_W(COORD_W), .ID_W(ID_W), .D2_W(D2_W)
) u_pcf_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_id_a(out_id_a), .out_id_b(out_id_b), .out_dx(out_dx),
  .out_dist2(out_dist2), .s1_vld(s1_vld), .keep_evt(keep_evt),
  .drop_evt(drop_evt), .s2_dist2(s2_dist2)
);

// File: tb/pair_cutoff_filter_tb.sv
module pair_cutoff_filter_tb;
  localparam int CW = 16;
  localparam int IW = 12;
  localparam int DW = 2*CW+2;
  localparam int NV = 12;

  // {id_a, id_b, ax, ay, az, bx, by, bz, expect_emit}, cutoff^2 = 1024
  localparam logic [120:0] VEC [NV] = '{
    {12'd1,  12'd2,  16'd100,   16'd100, 16'd100,  16'd110,   16'd100, 16'd100,  1'b1},
    {12'd1,  12'd3,  16'd100,   16'd100, 16'd100,  16'd132,   16'd100, 16'd100,  1'b0},
    {12'd1,  12'd4,  16'd100,   16'd100, 16'd100,  16'd131,   16'd100, 16'd100,  1'b1},
    {12'd8,  12'd9,  16'd200,   16'd200, 16'd200,  16'd190,   16'd210, 16'd205,  1'b1},
    {12'd5,  12'd5,  16'd300,   16'd300, 16'd300,  16'd300,   16'd300, 16'd300,  1'b0},
    {12'd7,  12'd7,  16'd300,   16'd300, 16'd300,  16'd301,   16'd300, 16'd300,  1'b0},
    {12'd10, 12'd11, 16'd0,     16'd0,   16'd0,    16'd65535, 16'd65535, 16'd65535, 1'b0},
    {12'd12, 12'd13, 16'd65535, 16'd0,   16'd0,    16'd65515, 16'd0,   16'd20,   1'b1},
    {12'd14, 12'd15, 16'd50,    16'd50,  16'd50,   16'd68,    16'd68,  16'd68,   1'b1},
    {12'd14, 12'd16, 16'd50,    16'd50,  16'd50,   16'd69,    16'd69,  16'd69,   1'b0},
    {12'd3,  12'd4,  16'd1000,  16'd2000, 16'd3000, 16'd1000, 16'd2000, 16'd3000, 1'b1},
    {12'd17, 12'd18, 16'd10,    16'd20,  16'd30,   16'd0,     16'd0,   16'd0,    1'b0}
  };

  typedef struct packed {
    int     ia;
    int     ib;
    int     dx;
    int     dy;
    int     dz;
    longint d2;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [DW-1:0] cfg_rc2;
  logic          in_valid, in_ready;
  logic [IW-1:0] in_id_a, in_id_b;
  logic [CW-1:0] in_ax, in_ay, in_az, in_bx, in_by, in_bz;
  logic          out_valid, out_ready;
  logic [IW-1:0] out_id_a, out_id_b;
  logic [CW:0]   out_dx, out_dy, out_dz;
  logic [DW-1:0] out_dist2;

  always #5 clk = ~clk;

  pair_cutoff_filter #(.COORD_W(CW), .ID_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rc2(cfg_rc2),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_id_a(in_id_a), .in_id_b(in_id_b),
    .in_ax(in_ax), .in_ay(in_ay), .in_az(in_az),
    .in_bx(in_bx), .in_by(in_by), .in_bz(in_bz),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_id_a(out_id_a), .out_id_b(out_id_b),
    .out_dx(out_dx), .out_dy(out_dy), .out_dz(out_dz), .out_dist2(out_dist2)
  );

  int     n_cmp = 0;
  int     n_bad = 0;
  int     cycles = 0;
  int     bp_mode = 0;
  bit     cur_keep = 0;
  bit     accepted = 0;
  bit     hold_pending = 0;
  longint held_d2;
  int     held_ia;
  int     held_dx;
  logic [7:0] lfsr = 8'hA5;
  exp_t   q[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // One cycle: settle, check outputs, record any handshake, advance to the next falling edge
  task automatic tick();
    exp_t e;
    if (bp_mode == 1)      out_ready = lfsr[0];
    else if (bp_mode == 2) out_ready = 1'b0;
    else                   out_ready = 1'b1;
    #1;
    if (hold_pending) begin
      chk(out_valid && out_dist2 == DW'(held_d2) && int'(out_id_a) == held_ia &&
          int'($signed(out_dx)) == held_dx, "R7 stalled record held",
          longint'(out_dist2), held_d2);
    end
    hold_pending = 1'b0;
    if (out_valid && !out_ready) begin
      hold_pending = 1'b1;
      held_d2 = longint'(out_dist2);
      held_ia = int'(out_id_a);
      held_dx = int'($signed(out_dx));
      chk(!in_ready, "R9 in_ready low while refused", longint'(in_ready), 0);
    end
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R7 unexpected or duplicate record", longint'(out_dist2), -1);
      end else begin
        e = q.pop_front();
        chk(int'(out_id_a) == e.ia && int'(out_id_b) == e.ib, "R3 identifiers",
            longint'(out_id_a) * 4096 + longint'(out_id_b), longint'(e.ia) * 4096 + longint'(e.ib));
        chk(int'($signed(out_dx)) == e.dx && int'($signed(out_dy)) == e.dy &&
            int'($signed(out_dz)) == e.dz, "R3 displacement",
            longint'($signed(out_dx)), longint'(e.dx));
        chk(longint'(out_dist2) == e.d2, "R3 squared distance", longint'(out_dist2), e.d2);
      end
    end
    accepted = in_valid && in_ready;
    if (accepted && cur_keep) begin
      e.ia = int'(in_id_a);
      e.ib = int'(in_id_b);
      e.dx = int'(in_bx) - int'(in_ax);
      e.dy = int'(in_by) - int'(in_ay);
      e.dz = int'(in_bz) - int'(in_az);
      e.d2 = longint'(e.dx) * e.dx + longint'(e.dy) * e.dy + longint'(e.dz) * e.dz;
      q.push_back(e);
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    @(posedge clk);
    @(negedge clk);
    cycles++;
  endtask

  task automatic send(input int ia, input int ib, input int ax, input int ay, input int az,
                      input int bx, input int by, input int bz, input bit keep);
    in_valid = 1'b1;
    in_id_a = IW'(ia); in_id_b = IW'(ib);
    in_ax = CW'(ax); in_ay = CW'(ay); in_az = CW'(az);
    in_bx = CW'(bx); in_by = CW'(by); in_bz = CW'(bz);
    cur_keep = keep;
    do tick(); while (!accepted);
  endtask

  task automatic send_vec(input int i);
    logic [120:0] v;
    v = VEC[i];
    send(int'(v[120:109]), int'(v[108:97]), int'(v[96:81]), int'(v[80:65]), int'(v[64:49]),
         int'(v[48:33]), int'(v[32:17]), int'(v[16:1]), v[0]);
  endtask

  task automatic drain();
    in_valid = 1'b0;
    cur_keep = 1'b0;
    for (int k = 0; k < 100; k++) begin
      if (q.size() == 0 && !out_valid) break;
      tick();
    end
    for (int k = 0; k < 3; k++) tick();
    chk(q.size() == 0, "R7 no record lost", longint'(q.size()), 0);
  endtask

  task automatic set_cutoff(input longint v);
    cfg_we = 1'b1;
    cfg_rc2 = DW'(v);
    tick();
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
    summary();
    $finish;
  end

  initial begin
    int c0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_rc2 = '0; in_valid = 1'b0; out_ready = 1'b1;
    in_id_a = '0; in_id_b = '0;
    in_ax = '0; in_ay = '0; in_az = '0; in_bx = '0; in_by = '0; in_bz = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!out_valid, "R1 out_valid after reset", longint'(out_valid), 0);
    chk(in_ready, "R1 in_ready after reset", longint'(in_ready), 1);
    @(negedge clk);

    // Table walk with the reset cutoff (R1, R3, R4, R5), no back-pressure (R2)
    bp_mode = 0;
    c0 = cycles;
    for (int i = 0; i < NV; i++) send_vec(i);
    chk(cycles - c0 == NV, "R2 one pair per cycle", longint'(cycles - c0), NV);
    drain();

    // Fixed latency R6: accepted at edge E, visible right after E+2
    send(20, 21, 10, 10, 10, 12, 10, 10, 1'b1);
    in_valid = 1'b0; cur_keep = 1'b0;
    chk(!out_valid, "R6 not after E", longint'(out_valid), 0);
    tick();
    chk(!out_valid, "R6 not after E+1", longint'(out_valid), 0);
    tick();
    chk(out_valid, "R6 valid after E+2", longint'(out_valid), 1);
    drain();

    // Discarded pairs do not stall while out_ready is low (R9, R4, R5)
    bp_mode = 2;
    c0 = cycles;
    send_vec(1); send_vec(4); send_vec(6); send_vec(9);
    chk(cycles - c0 == 4, "R9 drops never stall", longint'(cycles - c0), 4);
    in_valid = 1'b0;
    tick(); tick(); tick();
    chk(!out_valid, "R4 nothing emitted for dropped pairs", longint'(out_valid), 0);
    bp_mode = 0;
    drain();

    // Table walk under pseudo-random back-pressure (R7, R9)
    bp_mode = 1;
    for (int i = 0; i < NV; i++) send_vec(i);
    drain();
    bp_mode = 0;
    drain();

    // Cutoff register writes (R8)
    set_cutoff(101);
    send_vec(0);
    send(8, 9, 200, 200, 200, 190, 210, 205, 1'b0);
    drain();
    set_cutoff(226);
    send(8, 9, 200, 200, 200, 190, 210, 205, 1'b1);
    send(8, 9, 200, 200, 200, 190, 210, 206, 1'b0);
    drain();

    // Zero cutoff drops even zero distance (R4)
    set_cutoff(0);
    send(3, 4, 500, 500, 500, 500, 500, 500, 1'b0);
    drain();

    summary();
    $finish;
  end
endmodule